// File: doc/BRIEF.md
# Overclocking Profile Header Decoder and Timing Assembler

This block watches an indexed byte stream that carries the top region (indices 176 to 255) of a memory-module description image. It checks the two-byte signature of the overclocking-profile header and reports which of the two profiles are switched on and how many modules per channel each one is meant for. It also reports the header version and the time-base numerator and denominator of each profile.

For one profile, chosen when a new scan starts, it keeps the bytes that carry the wide timing fields. From them it rebuilds 12-bit and 16-bit timings in time-base units, plus three signed command-turnaround adjustments. If the chosen profile cannot be used, the timing outputs stay at zero and an error flag is raised. Nonzero bits in reserved positions raise a separate sticky flag, and extraction goes on as normal. A host feeds the image once after each `clear` pulse and reads the outputs when the stream has ended.

Top module: `xprof_decoder`

## Requirements
- R1: `hdr_ok` is 1 only when, since the last clear or reset, index 176 last carried 0x0C and index 177 last carried 0x4A.
- R2: `prof_enable[0]` follows bit 0 and `prof_enable[1]` follows bit 1 of the byte at index 178.
- R3: `prof1_dpc` equals bits 3:2 of index 178 plus one, and `prof2_dpc` equals bits 5:4 plus one, so each reads 1 to 4.
- R4: `ver_major` and `ver_minor` are bits 7:4 and 3:0 of index 179. The time-base numerator and denominator are indices 180 and 181 for profile 1, and 182 and 183 for profile 2.
- R5: `sel_prof` is sampled on a clear. 0 picks the profile whose offset 0 is index 185, and 1 picks the one at index 220. Bytes of the other profile change no timing output and no flag.
- R6: `t_ras` is {offset 9 bits 3:0, offset 10}. `t_rc` is {offset 9 bits 7:4, offset 11}.
- R7: `t_refi` is {offset 13, offset 12} and `t_rfc` is {offset 15, offset 14}, each stored low byte first. `t_faw` is {offset 18 bits 3:0, offset 19}.
- R8: Each turnaround adjustment is a 4-bit two's-complement value built from a 3-bit magnitude and the sign bit above it. A sign of 1 (push-out) gives +magnitude and a sign of 0 (pull-in) gives -magnitude. Write-to-read uses offset 21 bits 2:0 and 3. Read-to-write uses offset 21 bits 6:4 and 7. Back-to-back uses offset 22 bits 2:0 and 3.
- R9: `profile_error` is 1 when `hdr_ok` is 0 or when the enable bit of the chosen profile is 0. While it is 1, every timing and adjustment output reads zero.
- R10: `reserved_violation` goes to 1 and stays there until a clear or reset when a nonzero reserved bit is seen. The reserved positions are index 178 bits 7:6, index 184, and, in the chosen profile, offset 0 bit 7, offset 4 bit 7, offset 18 bits 7:4, offset 22 bits 7:4 and offsets 25 to 33. The flag does not stop extraction.
- R11: Reset, or a clear that takes priority over a byte in the same cycle, sets every captured byte to zero. A byte accepted on a clock edge shows on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Starts a new scan and samples `sel_prof` |
| sel_prof | input | 1 | Profile choice: 0 = first, 1 = second |
| byte_valid | input | 1 | Byte present on this cycle |
| byte_idx | input | 8 | Image index of the byte |
| byte_data | input | 8 | Byte value |
| hdr_ok | output | 1 | Signature matches |
| prof_enable | output | 2 | Per-profile enable bits |
| prof1_dpc | output | 3 | Modules per channel, profile 1 |
| prof2_dpc | output | 3 | Modules per channel, profile 2 |
| ver_major | output | 4 | Header major version |
| ver_minor | output | 4 | Header minor version |
| tb1_num | output | 8 | Time-base numerator, profile 1 |
| tb1_den | output | 8 | Time-base denominator, profile 1 |
| tb2_num | output | 8 | Time-base numerator, profile 2 |
| tb2_den | output | 8 | Time-base denominator, profile 2 |
| profile_error | output | 1 | Chosen profile not usable |
| reserved_violation | output | 1 | Sticky reserved-bit flag |
| t_ras | output | 12 | Active-to-precharge minimum |
| t_rc | output | 12 | Active-to-active minimum |
| t_refi | output | 16 | Average refresh interval |
| t_rfc | output | 16 | Refresh recovery minimum |
| t_faw | output | 12 | Four-activate window minimum |
| adj_wr2rd | output | 4 | Signed write-to-read adjustment |
| adj_rd2wr | output | 4 | Signed read-to-write adjustment |
| adj_b2b | output | 4 | Signed back-to-back adjustment |

## Verification
The hardest case to reach is the one where the same byte pattern means different things depending on which profile was chosen at the last clear. A reserved or timing byte of the other profile must leave both the flag and the timings untouched. The stimulus clears with one choice and then writes a nonzero byte into the other profile's reserved range and timing offsets. The bench checks the flag and timings before anything else is written. It then repeats the scan with the other choice and checks that the same indices now take effect.

// File: rtl/xprof_pkg.sv
package xprof_pkg;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 8;
    localparam int PROF_LEN = 35;

    localparam logic [IDX_W-1:0] IX_SIG0   = 8'd176;
    localparam logic [IDX_W-1:0] IX_SIG1   = 8'd177;
    localparam logic [IDX_W-1:0] IX_CFG    = 8'd178;
    localparam logic [IDX_W-1:0] IX_VER    = 8'd179;
    localparam logic [IDX_W-1:0] IX_TB1N   = 8'd180;
    localparam logic [IDX_W-1:0] IX_TB1D   = 8'd181;
    localparam logic [IDX_W-1:0] IX_TB2N   = 8'd182;
    localparam logic [IDX_W-1:0] IX_TB2D   = 8'd183;
    localparam logic [IDX_W-1:0] IX_HPAD   = 8'd184;
    localparam logic [IDX_W-1:0] P1_START  = 8'd185;
    localparam logic [IDX_W-1:0] P2_START  = 8'd220;

    localparam logic [BYTE_W-1:0] SIG0_VAL = 8'h0C;
    localparam logic [BYTE_W-1:0] SIG1_VAL = 8'h4A;

    // offsets inside one profile
    localparam int OF_VOLT   = 0;
    localparam int OF_CL_HI  = 4;
    localparam int OF_HINIB  = 9;
    localparam int OF_RAS_LO = 10;
    localparam int OF_RC_LO  = 11;
    localparam int OF_REFI_L = 12;
    localparam int OF_REFI_H = 13;
    localparam int OF_RFC_L  = 14;
    localparam int OF_RFC_H  = 15;
    localparam int OF_FAW_H  = 18;
    localparam int OF_FAW_L  = 19;
    localparam int OF_TA_A   = 21;
    localparam int OF_TA_B   = 22;
    localparam int OF_PAD_LO = 25;
    localparam int OF_PAD_HI = 33;

    typedef struct packed {
        logic [BYTE_W-1:0] sig0;
        logic [BYTE_W-1:0] sig1;
        logic [BYTE_W-1:0] cfg;
        logic [BYTE_W-1:0] ver;
        logic [BYTE_W-1:0] tb1n;
        logic [BYTE_W-1:0] tb1d;
        logic [BYTE_W-1:0] tb2n;
        logic [BYTE_W-1:0] tb2d;
    } hdr_raw_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hinib;
        logic [BYTE_W-1:0] ras_lo;
        logic [BYTE_W-1:0] rc_lo;
        logic [BYTE_W-1:0] refi_lo;
        logic [BYTE_W-1:0] refi_hi;
        logic [BYTE_W-1:0] rfc_lo;
        logic [BYTE_W-1:0] rfc_hi;
        logic [BYTE_W-1:0] faw_hi;
        logic [BYTE_W-1:0] faw_lo;
        logic [BYTE_W-1:0] ta_a;
        logic [BYTE_W-1:0] ta_b;
    } prof_raw_t;

    typedef struct packed {
        logic [11:0] ras;
        logic [11:0] rc;
        logic [15:0] refi;
        logic [15:0] rfc;
        logic [11:0] faw;
        logic [3:0]  wr2rd;
        logic [3:0]  rd2wr;
        logic [3:0]  b2b;
    } timing_t;

    // 3-bit magnitude with sign above: 1 = push-out (+), 0 = pull-in (-)
    function automatic logic [3:0] sign_mag(input logic [3:0] f);
        logic [3:0] m;
        m = {1'b0, f[2:0]};
        return f[3] ? m : (4'd0 - m);
    endfunction

    function automatic logic [2:0] dpc_count(input logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction
endpackage

// File: rtl/xprof_hdr_capture.sv
module xprof_hdr_capture
    import xprof_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              byte_valid,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [BYTE_W-1:0] byte_data,
    output hdr_raw_t          hdr_q,
    output logic              rsv_hit
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hdr_q <= '0;
        end else if (byte_valid) begin
            case (byte_idx)
                IX_SIG0: hdr_q.sig0 <= byte_data;
                IX_SIG1: hdr_q.sig1 <= byte_data;
                IX_CFG:  hdr_q.cfg  <= byte_data;
                IX_VER:  hdr_q.ver  <= byte_data;
                IX_TB1N: hdr_q.tb1n <= byte_data;
                IX_TB1D: hdr_q.tb1d <= byte_data;
                IX_TB2N: hdr_q.tb2n <= byte_data;
                IX_TB2D: hdr_q.tb2d <= byte_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        rsv_hit = 1'b0;
        if (byte_valid && !clear) begin
            if (byte_idx == IX_CFG && byte_data[7:6] != 2'b00) rsv_hit = 1'b1;
            if (byte_idx == IX_HPAD && byte_data != '0)        rsv_hit = 1'b1;
        end
    end
endmodule

// File: rtl/xprof_prof_capture.sv
module xprof_prof_capture
    import xprof_pkg::*;
#(
    parameter logic [IDX_W-1:0] BASE_A = P1_START,
    parameter logic [IDX_W-1:0] BASE_B = P2_START
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sel_prof,
    input  logic              byte_valid,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              sel_q,
    output prof_raw_t         prof_q,
    output logic              rsv_hit
);
    localparam int OFF_W = IDX_W;

    logic [IDX_W-1:0] base;
    logic [OFF_W-1:0] off;
    logic             in_rng;

    always_comb begin
        base   = sel_q ? BASE_B : BASE_A;
        off    = byte_idx - base;
        in_rng = byte_valid && !clear && (byte_idx >= base)
                 && (off < OFF_W'(PROF_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            prof_q <= '0;
        end else if (clear) begin
            sel_q  <= sel_prof;
            prof_q <= '0;
        end else if (in_rng) begin
            case (int'(off))
                OF_HINIB:  prof_q.hinib   <= byte_data;
                OF_RAS_LO: prof_q.ras_lo  <= byte_data;
                OF_RC_LO:  prof_q.rc_lo   <= byte_data;
                OF_REFI_L: prof_q.refi_lo <= byte_data;
                OF_REFI_H: prof_q.refi_hi <= byte_data;
                OF_RFC_L:  prof_q.rfc_lo  <= byte_data;
                OF_RFC_H:  prof_q.rfc_hi  <= byte_data;
                OF_FAW_H:  prof_q.faw_hi  <= byte_data;
                OF_FAW_L:  prof_q.faw_lo  <= byte_data;
                OF_TA_A:   prof_q.ta_a    <= byte_data;
                OF_TA_B:   prof_q.ta_b    <= byte_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        rsv_hit = 1'b0;
        if (in_rng) begin
            if ((int'(off) == OF_VOLT || int'(off) == OF_CL_HI) && byte_data[7])
                rsv_hit = 1'b1;
            if ((int'(off) == OF_FAW_H || int'(off) == OF_TA_B) && byte_data[7:4] != 4'd0)
                rsv_hit = 1'b1;
            if (int'(off) >= OF_PAD_LO && int'(off) <= OF_PAD_HI && byte_data != '0)
                rsv_hit = 1'b1;
        end
    end
endmodule

// File: rtl/xprof_assemble.sv
module xprof_assemble
    import xprof_pkg::*;
(
    input  prof_raw_t raw,
    input  logic      block,
    output timing_t   tim
);
    timing_t t;

    always_comb begin
        t.ras   = {raw.hinib[3:0], raw.ras_lo};
        t.rc    = {raw.hinib[7:4], raw.rc_lo};
        t.refi  = {raw.refi_hi, raw.refi_lo};
        t.rfc   = {raw.rfc_hi, raw.rfc_lo};
        t.faw   = {raw.faw_hi[3:0], raw.faw_lo};
        t.wr2rd = sign_mag(raw.ta_a[3:0]);
        t.rd2wr = sign_mag(raw.ta_a[7:4]);
        t.b2b   = sign_mag(raw.ta_b[3:0]);
        tim     = block ? '0 : t;
    end
endmodule

// File: rtl/xprof_decoder.sv
module xprof_decoder
    import xprof_pkg::*;
#(
    parameter logic [IDX_W-1:0] PROF1_BASE = P1_START,
    parameter logic [IDX_W-1:0] PROF2_BASE = P2_START
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        sel_prof,
    input  logic        byte_valid,
    input  logic [7:0]  byte_idx,
    input  logic [7:0]  byte_data,
    output logic        hdr_ok,
    output logic [1:0]  prof_enable,
    output logic [2:0]  prof1_dpc,
    output logic [2:0]  prof2_dpc,
    output logic [3:0]  ver_major,
    output logic [3:0]  ver_minor,
    output logic [7:0]  tb1_num,
    output logic [7:0]  tb1_den,
    output logic [7:0]  tb2_num,
    output logic [7:0]  tb2_den,
    output logic        profile_error,
    output logic        reserved_violation,
    output logic [11:0] t_ras,
    output logic [11:0] t_rc,
    output logic [15:0] t_refi,
    output logic [15:0] t_rfc,
    output logic [11:0] t_faw,
    output logic [3:0]  adj_wr2rd,
    output logic [3:0]  adj_rd2wr,
    output logic [3:0]  adj_b2b
);
    hdr_raw_t  hdr_q;
    prof_raw_t prof_q;
    timing_t   tim;
    logic      sel_q;
    logic      hdr_rsv, prof_rsv;
    logic      rsv_q;

    xprof_hdr_capture u_hdr (
        .clk(clk), .rst(rst), .clear(clear),
        .byte_valid(byte_valid), .byte_idx(byte_idx), .byte_data(byte_data),
        .hdr_q(hdr_q), .rsv_hit(hdr_rsv)
    );

    xprof_prof_capture #(.BASE_A(PROF1_BASE), .BASE_B(PROF2_BASE)) u_prof (
        .clk(clk), .rst(rst), .clear(clear), .sel_prof(sel_prof),
        .byte_valid(byte_valid), .byte_idx(byte_idx), .byte_data(byte_data),
        .sel_q(sel_q), .prof_q(prof_q), .rsv_hit(prof_rsv)
    );

    always_ff @(posedge clk) begin
        if (rst || clear) rsv_q <= 1'b0;
        else if (hdr_rsv || prof_rsv) rsv_q <= 1'b1;
    end

    always_comb begin
        hdr_ok        = (hdr_q.sig0 == SIG0_VAL) && (hdr_q.sig1 == SIG1_VAL);
        prof_enable   = hdr_q.cfg[1:0];
        prof1_dpc     = dpc_count(hdr_q.cfg[3:2]);
        prof2_dpc     = dpc_count(hdr_q.cfg[5:4]);
        ver_major     = hdr_q.ver[7:4];
        ver_minor     = hdr_q.ver[3:0];
        tb1_num       = hdr_q.tb1n;
        tb1_den       = hdr_q.tb1d;
        tb2_num       = hdr_q.tb2n;
        tb2_den       = hdr_q.tb2d;
        profile_error = !hdr_ok || !prof_enable[sel_q];
        reserved_violation = rsv_q;
    end

    xprof_assemble u_asm (.raw(prof_q), .block(profile_error), .tim(tim));

    always_comb begin
        t_ras     = tim.ras;
        t_rc      = tim.rc;
        t_refi    = tim.refi;
        t_rfc     = tim.rfc;
        t_faw     = tim.faw;
        adj_wr2rd = tim.wr2rd;
        adj_rd2wr = tim.rd2wr;
        adj_b2b   = tim.b2b;
    end
endmodule

// File: rtl/xprof_decoder_chk.sv
module xprof_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        clear,
    input logic        byte_valid,
    input logic        hdr_ok,
    input logic [2:0]  prof1_dpc,
    input logic [2:0]  prof2_dpc,
    input logic        profile_error,
    input logic        reserved_violation,
    input logic [11:0] t_ras,
    input logic [11:0] t_rc,
    input logic [15:0] t_refi,
    input logic [15:0] t_rfc,
    input logic [11:0] t_faw,
    input logic [3:0]  adj_wr2rd,
    input logic [3:0]  adj_rd2wr,
    input logic [3:0]  adj_b2b
);
    AST_ERR_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        profile_error |-> (t_ras == 0 && t_rc == 0 && t_refi == 0 && t_rfc == 0
                           && t_faw == 0 && adj_wr2rd == 0 && adj_rd2wr == 0 && adj_b2b == 0)); // R9
    AST_BAD_SIG_ERR: assert property (@(posedge clk) disable iff (rst)
        !hdr_ok |-> profile_error); // R9
    AST_DPC_RANGE: assert property (@(posedge clk) disable iff (rst)
        (prof1_dpc != 3'd0 && prof1_dpc <= 3'd4 && prof2_dpc != 3'd0 && prof2_dpc <= 3'd4)); // R3
    AST_RSV_STICKY: assert property (@(posedge clk) disable iff (rst)
        (reserved_violation && !clear) |=> reserved_violation); // R10
    AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!hdr_ok && !reserved_violation && t_ras == 0)); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!byte_valid && !clear) |=> ($stable(hdr_ok) && $stable(t_ras) && $stable(t_refi)
                                     && $stable(reserved_violation))); // R11
endmodule

bind xprof_decoder xprof_decoder_chk u_chk (.*);

// File: tb/tb_xprof_decoder.sv
module tb_xprof_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clear = 1'b0;
    logic        sel_prof = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_idx = '0;
    logic [7:0]  byte_data = '0;
    logic        hdr_ok, profile_error, reserved_violation;
    logic [1:0]  prof_enable;
    logic [2:0]  prof1_dpc, prof2_dpc;
    logic [3:0]  ver_major, ver_minor, adj_wr2rd, adj_rd2wr, adj_b2b;
    logic [7:0]  tb1_num, tb1_den, tb2_num, tb2_den;
    logic [11:0] t_ras, t_rc, t_faw;
    logic [15:0] t_refi, t_rfc;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xprof_decoder dut (.*);

    // vector: sel, offset9, offset10, offset11, expected t_ras, expected t_rc
    typedef struct packed {
        logic        sel;
        logic [7:0]  b9, b10, b11;
        logic [11:0] ras, rc;
    } vec_t;
    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h3A, 8'h20, 8'h44, 12'hA20, 12'h344},
        '{1'b1, 8'h01, 8'hFF, 8'h00, 12'h1FF, 12'h000},
        '{1'b0, 8'hF0, 8'h00, 8'hFF, 12'h000, 12'hFFF},
        '{1'b1, 8'h5C, 8'h18, 8'hC6, 12'hC18, 12'h5C6}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] idx, input logic [7:0] data);
        byte_valid = 1'b1; byte_idx = idx; byte_data = data;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic do_clear(input logic s);
        clear = 1'b1; sel_prof = s;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic header(input logic [7:0] cfg);
        put(8'd176, 8'h0C); put(8'd177, 8'h4A); put(8'd178, cfg);
        put(8'd179, 8'h12); put(8'd180, 8'd8); put(8'd181, 8'd1);
        put(8'd182, 8'd12); put(8'd183, 8'd1); put(8'd184, 8'h00);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R11 reset hdr_ok", hdr_ok, 0);
        chk("R9 reset profile_error", profile_error, 1);
        chk("R11 reset t_ras", t_ras, 0);
        chk("R11 reset reserved", reserved_violation, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            do_clear(VECS[i].sel);
            header(8'h03);
            b = VECS[i].sel ? 8'd220 : 8'd185;
            put(b + 8'd9,  VECS[i].b9);
            put(b + 8'd10, VECS[i].b10);
            put(b + 8'd11, VECS[i].b11);
            chk("R6 t_ras vector", t_ras, VECS[i].ras);
            chk("R6 t_rc vector", t_rc, VECS[i].rc);
            chk("R5 profile usable", profile_error, 0);
        end

        // R1 signature
        do_clear(1'b0);
        put(8'd176, 8'h0C);
        chk("R1 half signature", hdr_ok, 0);
        put(8'd177, 8'h4B);
        chk("R1 wrong second byte", hdr_ok, 0);
        put(8'd177, 8'h4A);
        chk("R1 full signature", hdr_ok, 1);

        // R2 R3 R4 header fields
        put(8'd178, 8'h39);
        chk("R2 enables", prof_enable, 2'b01);
        chk("R3 dpc1", prof1_dpc, 3);
        chk("R3 dpc2", prof2_dpc, 4);
        put(8'd179, 8'h12); put(8'd180, 8'd8); put(8'd181, 8'd3);
        put(8'd182, 8'd16); put(8'd183, 8'd5);
        chk("R4 major", ver_major, 1);
        chk("R4 minor", ver_minor, 2);
        chk("R4 tb1", {tb1_num, tb1_den}, {8'd8, 8'd3});
        chk("R4 tb2", {tb2_num, tb2_den}, {8'd16, 8'd5});

        // R5 other profile ignored (sel 0 latched)
        put(8'd230, 8'h77);
        put(8'd245, 8'hFF);
        chk("R5 other profile timing", t_ras, 0);
        chk("R5 other profile reserved", reserved_violation, 0);

        // R7 wide fields, R8 adjustments (profile 1)
        put(8'd197, 8'h34); put(8'd198, 8'h12);
        put(8'd199, 8'hCD); put(8'd200, 8'hAB);
        put(8'd203, 8'h0B); put(8'd204, 8'h2C);
        chk("R7 t_refi", t_refi, 16'h1234);
        chk("R7 t_rfc", t_rfc, 16'hABCD);
        chk("R7 t_faw", t_faw, 12'hB2C);
        put(8'd206, 8'h5B); put(8'd207, 8'h07);
        chk("R8 wr2rd push-out", adj_wr2rd, 4'h3);
        chk("R8 rd2wr pull-in", adj_rd2wr, 4'hB);
        chk("R8 b2b pull-in", adj_b2b, 4'h9);
        chk("R10 clean so far", reserved_violation, 0);

        // R9 profile 2 disabled
        do_clear(1'b1);
        header(8'h39);
        put(8'd229, 8'h0F); put(8'd230, 8'h55);
        chk("R9 disabled error", profile_error, 1);
        chk("R9 disabled zero", t_ras, 0);

        // R10 reserved violations, extraction continues
        do_clear(1'b0);
        header(8'h03);
        put(8'd184, 8'h01);
        chk("R10 pad byte", reserved_violation, 1);
        put(8'd195, 8'h44);
        chk("R10 extraction continues", t_ras, 12'h044);
        chk("R10 sticky", reserved_violation, 1);
        do_clear(1'b0);
        chk("R11 clear flag", reserved_violation, 0);
        chk("R11 clear hdr", hdr_ok, 0);
        put(8'd210, 8'h01);
        chk("R10 profile pad", reserved_violation, 1);
        do_clear(1'b1);
        put(8'd203, 8'h10);
        chk("R5 unselected reserved", reserved_violation, 0);
        put(8'd238, 8'h10);
        chk("R10 faw high nibble", reserved_violation, 1);
        do_clear(1'b0);
        put(8'd178, 8'h80);
        chk("R10 cfg top bits", reserved_violation, 1);

        // R11 clear wins over byte
        do_clear(1'b0);
        header(8'h01);
        clear = 1'b1; byte_valid = 1'b1; byte_idx = 8'd195; byte_data = 8'hAA;
        @(negedge clk);
        clear = 1'b0; byte_valid = 1'b0;
        chk("R11 clear priority hdr", hdr_ok, 0);
        header(8'h01);
        chk("R11 clear priority byte", t_ras, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule